// File: doc/BRIEF.md
# Multifunction 32-Bit Arithmetic/Logic Unit

This block is a purely combinational arithmetic/logic unit for a 32-bit datapath. Two operands, `opnd_x` and `opnd_y`, a 5-bit immediate shift amount and an 8-bit control word come in. A 32-bit result, a zero indication and a signed-overflow indication go out. The control word selects one of four result classes: a barrel shift of `opnd_y`, a signed set-less-than comparison, an add or subtract, and a bitwise logic operation.

The adder is shared. It performs the arithmetic class and also produces the comparison for set-less-than, which always subtracts. The shift amount comes from the immediate field or from the low five bits of `opnd_x`. No clock or reset is involved, so every output follows its inputs within the same evaluation.

Top module: `multi_alu`

## Requirements
- R1: Control bits [7:6] pick the result class. 00 selects shift, 01 selects set-less-than, 10 selects add/subtract and 11 selects logic.
- R2: In the add/subtract class, control bit 5 = 0 gives `opnd_x + opnd_y` and bit 5 = 1 gives `opnd_x - opnd_y`, both modulo 2^32.
- R3: `ovfl_flag` is 1 only in the add/subtract class, and only when the two's-complement result of that operation does not fit in 32 bits. In every other class it is 0.
- R4: The set-less-than class returns 32'd1 when `opnd_x < opnd_y` as signed numbers and 0 otherwise. This holds for every operand pair, including pairs whose difference overflows, and it holds whatever the value of control bit 5.
- R5: In the shift class, control bits [3:2] act on `opnd_y`. 00 returns it unchanged, 01 shifts it left with zero fill, 10 shifts it right with zero fill, and 11 shifts it right filling with its bit 31.
- R6: Control bit 4 = 0 takes the shift amount from `shamt_imm`. Bit 4 = 1 takes it from `opnd_x[4:0]`, and bits 31:5 of `opnd_x` have no effect on the shift.
- R7: In the logic class, control bits [1:0] select 00 AND, 01 OR, 10 XOR and 11 NOR of the two operands.
- R8: `zero_flag` is 1 exactly when all 32 bits of `result` are 0, in every class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_x | input | 32 | First operand; its low bits supply the variable shift amount |
| opnd_y | input | 32 | Second operand; the value that gets shifted |
| shamt_imm | input | 5 | Immediate shift amount |
| ctrl | input | 8 | Control word: class[7:6], subtract[5], variable amount[4], shift fn[3:2], logic fn[1:0] |
| result | output | 32 | Selected result |
| zero_flag | output | 1 | High when result is all zeros |
| ovfl_flag | output | 1 | Signed overflow of the add/subtract class |

## Verification
Some properties are checked on every evaluation. The lookahead carry chain is compared against a plain sum. The overflow indication is compared against a sign-based rule and must stay low outside the arithmetic class. The comparison bit is compared against a signed less-than. The shifter is checked for keeping the sign on arithmetic right shifts and for zero fill on left shifts, and the NOR output must never share a set bit with either operand. The bench's directed scenarios cover what those local checks cannot see: whether the right class reaches `result` for each control encoding, whether the amount source is chosen correctly and the upper bits of `opnd_x` are ignored, the boundary values at ±2^31, and whether the zero flag follows the chosen result.

// File: rtl/multi_alu_pkg.sv
package multi_alu_pkg;

  localparam int unsigned CTRL_W = 8;

  typedef enum logic [1:0] {
    CLS_SHIFT = 2'b00,
    CLS_SLT   = 2'b01,
    CLS_ARITH = 2'b10,
    CLS_LOGIC = 2'b11
  } fn_class_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'b00,
    SH_LL   = 2'b01,
    SH_LR   = 2'b10,
    SH_AR   = 2'b11
  } shift_fn_e;

  typedef enum logic [1:0] {
    LG_AND = 2'b00,
    LG_OR  = 2'b01,
    LG_XOR = 2'b10,
    LG_NOR = 2'b11
  } logic_fn_e;

  // packed MSB first: cls[7:6] sub[5] amt_var[4] sh_fn[3:2] lg_fn[1:0]
  typedef struct packed {
    fn_class_e cls;
    logic      sub;
    logic      amt_var;
    shift_fn_e sh_fn;
    logic_fn_e lg_fn;
  } ctrl_word_t;

  // Sign-based overflow rule: equal operand signs, differing result sign.
  function automatic logic sign_rule_ovf(input logic a_msb, input logic b_msb,
                                         input logic s_msb);
    return (a_msb == b_msb) && (s_msb != a_msb);
  endfunction

endpackage

// File: rtl/alu_cla_adder.sv
module alu_cla_adder #(
  parameter int unsigned W   = 32,
  parameter int unsigned GRP = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf
);
  import multi_alu_pkg::*;

  localparam int unsigned NG = W / GRP;

  logic [W-1:0] b_eff;
  logic [W-1:0] prop;
  logic [W-1:0] gen;
  logic [W:0]   carry;

  assign b_eff = b ^ {W{sub}};
  assign prop  = a ^ b_eff;
  assign gen   = a & b_eff;

  // Group lookahead: each bit's carry is a sum of products from the
  // group carry-in; the group carry-out uses group generate/propagate.
  always_comb begin
    carry    = '0;
    carry[0] = sub;
    for (int gi = 0; gi < NG; gi++) begin
      logic gg;
      logic gp;
      for (int k = 0; k < int'(GRP) - 1; k++) begin
        logic run_p;
        logic acc;
        run_p = 1'b1;
        acc   = 1'b0;
        for (int j = k; j >= 0; j--) begin
          acc   = acc | (gen[gi*GRP+j] & run_p);
          run_p = run_p & prop[gi*GRP+j];
        end
        carry[gi*GRP+k+1] = acc | (run_p & carry[gi*GRP]);
      end
      gg = 1'b0;
      gp = 1'b1;
      for (int j = int'(GRP) - 1; j >= 0; j--) begin
        gg = gg | (gen[gi*GRP+j] & gp);
        gp = gp & prop[gi*GRP+j];
      end
      carry[(gi+1)*GRP] = gg | (gp & carry[gi*GRP]);
    end
  end

  assign sum = prop ^ carry[W-1:0];
  assign ovf = carry[W] ^ carry[W-1];

  always_comb begin
    // R2
    sum_ref_chk: assert (sum == W'(a + b_eff + W'(sub)));
    // R3
    ovf_rule_chk: assert (ovf == sign_rule_ovf(a[W-1], b_eff[W-1], sum[W-1]));
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned W    = 32,
  parameter int unsigned SH_W = $clog2(W)
) (
  input  logic [W-1:0]             din,
  input  logic [SH_W-1:0]          amt,
  input  multi_alu_pkg::shift_fn_e fn,
  output logic [W-1:0]             dout
);
  import multi_alu_pkg::*;

  function automatic logic [W-1:0] bit_rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < int'(W); i++) r[i] = v[W-1-i];
    return r;
  endfunction

  logic         go_left;
  logic         fill_bit;
  logic [W-1:0] stg [SH_W+1];
  logic [W-1:0] shifted;

  assign go_left  = (fn == SH_LL);
  assign fill_bit = (fn == SH_AR) & din[W-1];
  assign stg[0]   = go_left ? bit_rev(din) : din;

  // Right-shifting barrel, one stage per amount bit; left shifts reuse it
  // through bit reversal on both sides.
  generate
    for (genvar s = 0; s < int'(SH_W); s++) begin : g_stage
      localparam int unsigned D = 1 << s;
      assign stg[s+1] = amt[s] ? {{D{fill_bit}}, stg[s][W-1:D]} : stg[s];
    end
  endgenerate

  assign shifted = go_left ? bit_rev(stg[SH_W]) : stg[SH_W];
  assign dout    = (fn == SH_NONE) ? din : shifted;

  always_comb begin
    // R5
    sign_keep_chk: assert (!(fn == SH_AR) || (dout[W-1] == din[W-1]));
    // R5
    left_fill_chk: assert (!(fn == SH_LL && amt != '0) || (dout[0] == 1'b0));
  end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]             a,
  input  logic [W-1:0]             b,
  input  multi_alu_pkg::logic_fn_e fn,
  output logic [W-1:0]             dout
);
  import multi_alu_pkg::*;

  always_comb begin
    unique case (fn)
      LG_AND:  dout = a & b;
      LG_OR:   dout = a | b;
      LG_XOR:  dout = a ^ b;
      default: dout = ~(a | b);
    endcase
  end

  always_comb begin
    // R7
    nor_disjoint_chk: assert (!(fn == LG_NOR) || ((dout & (a | b)) == '0));
  end

endmodule

// File: rtl/multi_alu.sv
module multi_alu #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned GRP_W  = 4,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]               opnd_x,
  input  logic [DATA_W-1:0]               opnd_y,
  input  logic [SH_W-1:0]                 shamt_imm,
  input  logic [multi_alu_pkg::CTRL_W-1:0] ctrl,
  output logic [DATA_W-1:0]               result,
  output logic                            zero_flag,
  output logic                            ovfl_flag
);
  import multi_alu_pkg::*;

  ctrl_word_t       cw;
  logic [SH_W-1:0]  sh_amt;
  logic             sub_eff;
  logic [DATA_W-1:0] add_sum;
  logic             add_ovf;
  logic             slt_bit;
  logic [DATA_W-1:0] sh_out;
  logic [DATA_W-1:0] lg_out;

  assign cw      = ctrl_word_t'(ctrl);
  assign sh_amt  = cw.amt_var ? opnd_x[SH_W-1:0] : shamt_imm;
  assign sub_eff = cw.sub | (cw.cls == CLS_SLT);

  alu_cla_adder #(.W(DATA_W), .GRP(GRP_W)) adder_i (
    .a   (opnd_x),
    .b   (opnd_y),
    .sub (sub_eff),
    .sum (add_sum),
    .ovf (add_ovf)
  );

  alu_shifter #(.W(DATA_W), .SH_W(SH_W)) shifter_i (
    .din  (opnd_y),
    .amt  (sh_amt),
    .fn   (cw.sh_fn),
    .dout (sh_out)
  );

  alu_logic_unit #(.W(DATA_W)) logic_i (
    .a    (opnd_x),
    .b    (opnd_y),
    .fn   (cw.lg_fn),
    .dout (lg_out)
  );

  // Sign of the difference, corrected by the overflow of that difference.
  assign slt_bit = add_sum[DATA_W-1] ^ add_ovf;

  always_comb begin
    unique case (cw.cls)
      CLS_SHIFT: result = sh_out;
      CLS_SLT:   result = {{(DATA_W-1){1'b0}}, slt_bit};
      CLS_ARITH: result = add_sum;
      default:   result = lg_out;
    endcase
  end

  assign zero_flag = ~|result;
  assign ovfl_flag = (cw.cls == CLS_ARITH) & add_ovf;

  always_comb begin
    // R3
    ovfl_class_chk: assert (!ovfl_flag || (cw.cls == CLS_ARITH));
    // R4
    slt_signed_chk: assert (!(cw.cls == CLS_SLT) ||
                            (slt_bit == ($signed(opnd_x) < $signed(opnd_y))));
    // R4
    slt_width_chk: assert (!(cw.cls == CLS_SLT) || (result[DATA_W-1:1] == '0));
  end

endmodule

// File: tb/multi_alu_tb_top.sv
module multi_alu_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [31:0] opnd_x = '0;
  logic [31:0] opnd_y = '0;
  logic [4:0]  shamt_imm = '0;
  logic [7:0]  ctrl = '0;
  logic [31:0] result;
  logic        zero_flag;
  logic        ovfl_flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  multi_alu dut_i (
    .opnd_x    (opnd_x),
    .opnd_y    (opnd_y),
    .shamt_imm (shamt_imm),
    .ctrl      (ctrl),
    .result    (result),
    .zero_flag (zero_flag),
    .ovfl_flag (ovfl_flag)
  );

  function automatic logic [7:0] mk(input logic [1:0] cls, input logic sub,
                                    input logic av, input logic [1:0] sf,
                                    input logic [1:0] lf);
    return {cls, sub, av, sf, lf};
  endfunction

  // Independent model: returns {ovfl, zero, result}
  function automatic logic [33:0] model(input logic [31:0] x, input logic [31:0] y,
                                        input logic [4:0] imm, input logic [7:0] c);
    logic [31:0] r;
    logic        v;
    logic [4:0]  amt;
    longint      sx, sy, lr;
    v   = 1'b0;
    r   = '0;
    amt = c[4] ? x[4:0] : imm;
    sx  = longint'($signed(x));
    sy  = longint'($signed(y));
    case (c[7:6])
      2'b00: case (c[3:2])
               2'b00: r = y;
               2'b01: r = y << amt;
               2'b10: r = y >> amt;
               default: r = $unsigned($signed(y) >>> amt);
             endcase
      2'b01: r = (sx < sy) ? 32'd1 : 32'd0;
      2'b10: begin
               lr = c[5] ? (sx - sy) : (sx + sy);
               r  = lr[31:0];
               v  = (lr > 64'sd2147483647) || (lr < -64'sd2147483648);
             end
      default: case (c[1:0])
               2'b00: r = x & y;
               2'b01: r = x | y;
               2'b10: r = x ^ y;
               default: r = ~(x | y);
             endcase
    endcase
    return {v, (r == 32'd0), r};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_vec(input string tag, input logic [31:0] x, input logic [31:0] y,
                         input logic [4:0] imm, input logic [7:0] c);
    logic [33:0] e;
    e = model(x, y, imm, c);
    @(posedge clk);
    #1;
    opnd_x = x; opnd_y = y; shamt_imm = imm; ctrl = c;
    #2;
    check({tag, " result"}, result, e[31:0]);
    check({"R8 zero ", tag}, {31'd0, zero_flag}, {31'd0, e[32]});
    check({"R3 ovfl ", tag}, {31'd0, ovfl_flag}, {31'd0, e[33]});
  endtask

  task automatic t_idle();
    // R8: all-zero inputs, AND class gives zero result with zero flag set
    run_vec("R8 idle", 32'h0, 32'h0, 5'd0, 8'h00);
    run_vec("R8 idle_and", 32'h0, 32'h0, 5'd0, mk(2'b11, 1'b0, 1'b0, 2'b00, 2'b00));
  endtask

  task automatic t_arith();
    logic [7:0] add_c, sub_c;
    add_c = mk(2'b10, 1'b0, 1'b0, 2'b00, 2'b00);
    sub_c = mk(2'b10, 1'b1, 1'b0, 2'b00, 2'b00);
    run_vec("R2 add", 32'd1234, 32'd4321, 5'd0, add_c);
    run_vec("R2 sub", 32'd100, 32'd250, 5'd0, sub_c);
    run_vec("R2 sub_zero", 32'hDEADBEEF, 32'hDEADBEEF, 5'd0, sub_c);
    run_vec("R3 add_posovf", 32'h7FFFFFFF, 32'h1, 5'd0, add_c);
    run_vec("R3 add_negovf", 32'h80000000, 32'hFFFFFFFF, 5'd0, add_c);
    run_vec("R3 sub_ovf", 32'h80000000, 32'h1, 5'd0, sub_c);
    run_vec("R3 sub_minneg", 32'h0, 32'h80000000, 5'd0, sub_c);
    run_vec("R2 carry_no_ovf", 32'hFFFFFFFF, 32'h1, 5'd0, add_c);
  endtask

  task automatic t_slt();
    logic [7:0] s0, s1;
    s0 = mk(2'b01, 1'b0, 1'b0, 2'b00, 2'b00);
    s1 = mk(2'b01, 1'b1, 1'b0, 2'b00, 2'b00);
    run_vec("R4 lt", 32'd3, 32'd9, 5'd0, s0);
    run_vec("R4 gt", 32'd9, 32'd3, 5'd0, s1);
    run_vec("R4 equal", 32'h5555AAAA, 32'h5555AAAA, 5'd0, s0);
    run_vec("R4 neg_vs_pos", 32'hFFFFFFFF, 32'h1, 5'd0, s0);
    run_vec("R4 ovf_lt", 32'h80000000, 32'h1, 5'd0, s1);
    run_vec("R4 ovf_gt", 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, s0);
    run_vec("R4 unsigned_trap", 32'h1, 32'h80000000, 5'd0, s1);
  endtask

  task automatic t_shift();
    run_vec("R5 none", 32'h0, 32'h9ABCDEF0, 5'd7, mk(2'b00, 1'b0, 1'b0, 2'b00, 2'b00));
    run_vec("R5 ll", 32'h0, 32'h80000001, 5'd4, mk(2'b00, 1'b0, 1'b0, 2'b01, 2'b00));
    run_vec("R5 lr", 32'h0, 32'h80000001, 5'd4, mk(2'b00, 1'b0, 1'b0, 2'b10, 2'b00));
    run_vec("R5 ar_neg", 32'h0, 32'h80000010, 5'd4, mk(2'b00, 1'b0, 1'b0, 2'b11, 2'b00));
    run_vec("R5 ar_pos", 32'h0, 32'h40000010, 5'd31, mk(2'b00, 1'b0, 1'b0, 2'b11, 2'b00));
    run_vec("R5 ar_31", 32'h0, 32'h80000000, 5'd31, mk(2'b00, 1'b0, 1'b0, 2'b11, 2'b00));
    run_vec("R5 ll_31", 32'h0, 32'h00000003, 5'd31, mk(2'b00, 1'b0, 1'b0, 2'b01, 2'b00));
    run_vec("R5 lr_0", 32'h0, 32'hF0F0F0F0, 5'd0, mk(2'b00, 1'b0, 1'b0, 2'b10, 2'b00));
    // R6: variable amount from x[4:0], upper bits of x set to junk
    run_vec("R6 var_lr", 32'hFFFFFFE8, 32'hFF000000, 5'd1, mk(2'b00, 1'b0, 1'b1, 2'b10, 2'b00));
    run_vec("R6 var_ll", 32'hABCDEF03, 32'h00000011, 5'd20, mk(2'b00, 1'b0, 1'b1, 2'b01, 2'b00));
    run_vec("R6 imm_over_x", 32'hFFFFFFFF, 32'h00000100, 5'd8, mk(2'b00, 1'b0, 1'b0, 2'b10, 2'b00));
    run_vec("R6 var_zero", 32'h12345660, 32'h80000000, 5'd9, mk(2'b00, 1'b0, 1'b1, 2'b11, 2'b00));
  endtask

  task automatic t_logic();
    logic [31:0] a, b;
    a = 32'hF0F0CC33;
    b = 32'hFF00AA55;
    for (int f = 0; f < 4; f++) begin
      run_vec($sformatf("R7 fn%0d", f), a, b, 5'd0, mk(2'b11, 1'b0, 1'b0, 2'b00, f[1:0]));
    end
    run_vec("R7 nor_ones", 32'hFFFF0000, 32'h0000FFFF, 5'd0, mk(2'b11, 1'b0, 1'b0, 2'b00, 2'b11));
    run_vec("R8 xor_self", 32'h13579BDF, 32'h13579BDF, 5'd0, mk(2'b11, 1'b0, 1'b0, 2'b00, 2'b10));
  endtask

  task automatic t_class();
    // R1: same operands, each class; overflow-prone pair shows R3 gating
    logic [31:0] a, b;
    a = 32'h7FFFFFFF;
    b = 32'h00000003;
    for (int k = 0; k < 4; k++) begin
      run_vec($sformatf("R1 class%0d", k), a, b, 5'd2, mk(k[1:0], 1'b0, 1'b0, 2'b01, 2'b01));
    end
  endtask

  task automatic t_sweep();
    logic [31:0] st;
    st = 32'h2545F491;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] x, y, cw;
      st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5); x  = st;
      st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5); y  = st;
      st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5); cw = st;
      if (i % 7 == 0) y = x;
      run_vec($sformatf("R1 sweep%0d", i), x, y, cw[12:8], cw[7:0]);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_idle();
    t_arith();
    t_slt();
    t_shift();
    t_logic();
    t_class();
    t_sweep();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule